// File: doc/BRIEF.md
# Pushbutton Master Volume Controller

This block lets two active-low pushbuttons set the codec master volume with no software involved. It keeps a shadow copy of the codec master-volume register. A software write to that register is stored in the shadow. A debounced button press moves both attenuation fields one step, and pressing both buttons together toggles the mute bit. Each change that the buttons make is offered to the codec-link controller as a single register-write request, using a valid/ready handshake.

The two button pins double as serial-memory pins, so a mode input chooses between the two uses. When the mode input is low, the buttons cannot alter the shadow. Software can read the shadow back at any time, so it always sees the value the codec was last given.

Shadow layout: bit 15 is mute, bits 12:8 hold the left attenuation and bits 4:0 hold the right attenuation, where 0 is loudest and 31 is quietest. Button steps leave every other bit as software wrote it.

Top module: `hwvol_ctrl`

## Requirements
- R1: Each button input passes through a two-stage synchronizer. A change of level counts only after it has held for DEBOUNCE consecutive clocks, so a pulse shorter than that has no effect on the shadow or on the request output.
- R2: A press of the up button lowers both attenuation fields (bits 12:8 and 4:0) by one. A press of the down button raises both by one. No field moves by more than one per step.
- R3: The fields saturate at 0 and at 31 and never wrap. A step that changes no field raises no request.
- R4: While one button is held, the first step occurs on the press, the second REPEAT_DELAY clocks after the first, and each later step REPEAT_RATE clocks after the one before it.
- R5: When both buttons become pressed together, mute (bit 15) toggles and the fields stay as they were. No step of any kind happens until both buttons are released.
- R6: A software write (sw_we) is readable on sw_rdata from the next clock. A software write never raises a request on its own, and the bits outside the fields and mute survive later button steps.
- R7: When a software write and a button change fall in the same clock, the software value is stored and the button change is dropped.
- R8: Each change made by the buttons raises cw_valid, with cw_addr equal to VOL_ADDR and cw_data equal to the shadow. cw_valid stays high until a clock in which cw_ready is high. Out of reset the shadow is RESET_VOL and cw_valid is low.
- R9: A change made while a request is still pending replaces the pending value. One acceptance then delivers the newest value, and no further request follows.
- R10: While vol_mode is low, the buttons do not change the shadow and raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vol_mode | input | 1 | 1: pins act as volume buttons; 0: buttons ignored |
| btn_up_n | input | 1 | Volume-up button, active low, asynchronous |
| btn_dn_n | input | 1 | Volume-down button, active low, asynchronous |
| sw_we | input | 1 | Software write strobe for the master-volume register |
| sw_wdata | input | 16 | Software write data |
| sw_rdata | output | 16 | Current shadow value |
| cw_valid | output | 1 | Codec write request pending |
| cw_addr | output | 7 | Codec register address of the request |
| cw_data | output | 16 | Codec register data of the request |
| cw_ready | input | 1 | Codec-link controller accepts the request |

## Verification
The bench exercises several corner cases:
- Saturation at both ends. A wrapping design would jump from 0 to 31, and a careless one would send a useless request for an unchanged value.
- A glitch shorter than the debounce window. A weak filter would take a step.
- A held button, where the step count is compared against the delay and repeat intervals. A repeat counter that is off by a whole interval would give a different count.
- Both buttons pressed at once. A wrong design steps or repeats instead of toggling mute.
- Two changes queued behind a stalled handshake. Two requests, or a stale value, would show the supersede rule broken.
- Software writes held across a button step. If the button path won, the written value would be lost.
- Mode low. Any shadow change at all would be an error.

// File: rtl/hwvol_ctrl.sv
module hwvol_ctrl #(
  parameter int DEBOUNCE     = 240000,
  parameter int REPEAT_DELAY = 12000000,
  parameter int REPEAT_RATE  = 2400000,
  parameter logic [6:0]  VOL_ADDR  = 7'h02,
  parameter logic [15:0] RESET_VOL = 16'h8000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        vol_mode,
  input  logic        btn_up_n,
  input  logic        btn_dn_n,
  input  logic        sw_we,
  input  logic [15:0] sw_wdata,
  output logic [15:0] sw_rdata,
  output logic        cw_valid,
  output logic [6:0]  cw_addr,
  input  logic        cw_ready,
  output logic [15:0] cw_data
);
  localparam int DB_W  = $clog2(DEBOUNCE + 1);
  localparam int RMAX  = (REPEAT_DELAY > REPEAT_RATE) ? REPEAT_DELAY : REPEAT_RATE;
  localparam int RC_W  = $clog2(RMAX + 1);
  localparam logic [DB_W-1:0] DB_LAST = DB_W'(DEBOUNCE - 1);
  localparam logic [RC_W-1:0] RD_LAST = RC_W'(REPEAT_DELAY - 1);
  localparam logic [RC_W-1:0] RR_LAST = RC_W'(REPEAT_RATE - 1);

  logic [1:0] pin_n, s1, s2, held, held_q;
  logic [15:0] shadow;
  logic        combo, first;
  logic [RC_W-1:0] rcnt;

  assign pin_n = {btn_dn_n, btn_up_n};

  for (genvar g = 0; g < 2; g++) begin : g_btn
    logic [DB_W-1:0] cnt;
    logic            raw;
    assign raw = vol_mode & ~s2[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1[g]   <= 1'b1;
        s2[g]   <= 1'b1;
        held[g] <= 1'b0;
        cnt     <= '0;
      end else begin
        s1[g] <= pin_n[g];
        s2[g] <= s1[g];
        if (raw == held[g]) cnt <= '0;
        else if (cnt == DB_LAST) begin
          held[g] <= raw;
          cnt     <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end
  end

  logic up, dn, single, press_edge, combo_hit, rep_fire, step_now, changed, bump;
  logic [4:0] l_now, r_now, l_nxt, r_nxt;
  logic [15:0] nxt;

  assign up = held[0];
  assign dn = held[1];
  assign single     = (up ^ dn) & ~combo;
  assign press_edge = (up & ~held_q[0] & ~dn) | (dn & ~held_q[1] & ~up);
  assign combo_hit  = up & dn & ~combo & ((up & ~held_q[0]) | (dn & ~held_q[1]));
  assign rep_fire   = single & ~press_edge & (rcnt == (first ? RD_LAST : RR_LAST));
  assign step_now   = single & (press_edge | rep_fire);

  assign l_now = shadow[12:8];
  assign r_now = shadow[4:0];
  assign l_nxt = up ? ((l_now == 5'd0) ? l_now : l_now - 5'd1)
                    : ((l_now == 5'd31) ? l_now : l_now + 5'd1);
  assign r_nxt = up ? ((r_now == 5'd0) ? r_now : r_now - 5'd1)
                    : ((r_now == 5'd31) ? r_now : r_now + 5'd1);
  assign nxt     = {shadow[15:13], l_nxt, shadow[7:5], r_nxt};
  assign changed = nxt != shadow;
  assign bump    = ~sw_we & vol_mode & (combo_hit | (step_now & changed));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= 2'b00;
      combo  <= 1'b0;
      first  <= 1'b1;
      rcnt   <= '0;
    end else begin
      held_q <= held;
      if (combo_hit) combo <= 1'b1;
      else if (!up && !dn) combo <= 1'b0;
      if (press_edge) begin
        rcnt  <= '0;
        first <= 1'b1;
      end else if (rep_fire) begin
        rcnt  <= '0;
        first <= 1'b0;
      end else if (single) rcnt <= rcnt + 1'b1;
      else begin
        rcnt  <= '0;
        first <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= RESET_VOL;
      cw_valid <= 1'b0;
    end else begin
      if (sw_we) shadow <= sw_wdata;
      else if (vol_mode && combo_hit) shadow[15] <= ~shadow[15];
      else if (vol_mode && step_now) shadow <= nxt;
      if (bump) cw_valid <= 1'b1;
      else if (cw_ready) cw_valid <= 1'b0;
    end
  end

  assign sw_rdata = shadow;
  assign cw_data  = shadow;
  assign cw_addr  = VOL_ADDR;

  a_r6_sw_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> sw_rdata == $past(sw_wdata));
  a_r8_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cw_valid && !cw_ready |=> cw_valid);
  a_r10_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    !vol_mode && !sw_we |=> sw_rdata == $past(sw_rdata));
  a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ({1'b0, sw_rdata[12:8]} == {1'b0, $past(sw_rdata[12:8])}) ||
               ({1'b0, sw_rdata[12:8]} == {1'b0, $past(sw_rdata[12:8])} + 6'd1) ||
               ({1'b0, sw_rdata[12:8]} + 6'd1 == {1'b0, $past(sw_rdata[12:8])}));
  a_r5_mute_alone: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> (sw_rdata[15] == $past(sw_rdata[15])) || (sw_rdata[4:0] == $past(sw_rdata[4:0])));
  a_r3_no_idle_req: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we && !cw_valid |=> !cw_valid || (sw_rdata != $past(sw_rdata)));
endmodule

// File: tb/sim_hwvol_ctrl.sv
module sim_hwvol_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DEB = 4;
  localparam int RDLY = 40;
  localparam int RRATE = 16;
  localparam logic [6:0] VADDR = 7'h02;

  logic clk = 0, rst_n = 0, vol_mode = 1, btn_up_n = 1, btn_dn_n = 1;
  logic sw_we = 0, cw_ready = 0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] sw_rdata, cw_data;
  logic cw_valid;
  logic [6:0] cw_addr;
  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwvol_ctrl #(.DEBOUNCE(DEB), .REPEAT_DELAY(RDLY), .REPEAT_RATE(RRATE),
               .VOL_ADDR(VADDR), .RESET_VOL(16'h8000)) u0 (
    .clk(clk), .rst_n(rst_n), .vol_mode(vol_mode), .btn_up_n(btn_up_n),
    .btn_dn_n(btn_dn_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .cw_valid(cw_valid), .cw_addr(cw_addr), .cw_ready(cw_ready), .cw_data(cw_data));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(logic [15:0] v);
    @(negedge clk); sw_we = 1; sw_wdata = v;
    @(negedge clk); sw_we = 0;
  endtask

  task automatic tap(logic up, logic dn, int hold);
    @(negedge clk); btn_up_n = ~up; btn_dn_n = ~dn;
    cycles(hold);
    btn_up_n = 1; btn_dn_n = 1;
    cycles(20);
  endtask

  task automatic accept;
    @(negedge clk); cw_ready = 1;
    @(negedge clk); cw_ready = 0;
  endtask

  task automatic t_reset;
    chk("R8 reset shadow", 32'(sw_rdata), 32'h8000);
    chk("R8 reset valid", 32'(cw_valid), 0);
  endtask

  task automatic t_sw_and_steps;
    sw_write(16'h0A45);
    chk("R6 sw capture", 32'(sw_rdata), 32'h0A45);
    chk("R6 sw no request", 32'(cw_valid), 0);
    tap(1, 0, 20);
    chk("R2 up step", 32'(sw_rdata), 32'h0944);
    chk("R8 valid", 32'(cw_valid), 1);
    chk("R8 addr", 32'(cw_addr), 32'(VADDR));
    chk("R8 data", 32'(cw_data), 32'h0944);
    cycles(5);
    chk("R8 valid held", 32'(cw_valid), 1);
    accept();
    chk("R8 valid dropped", 32'(cw_valid), 0);
    tap(0, 1, 20);
    chk("R2 down step", 32'(sw_rdata), 32'h0A45);
    accept();
  endtask

  task automatic t_saturate;
    sw_write(16'h0000);
    tap(1, 0, 20);
    chk("R3 floor", 32'(sw_rdata), 32'h0000);
    chk("R3 floor no req", 32'(cw_valid), 0);
    sw_write(16'h1F1F);
    tap(0, 1, 20);
    chk("R3 ceiling", 32'(sw_rdata), 32'h1F1F);
    chk("R3 ceiling no req", 32'(cw_valid), 0);
    sw_write(16'h001F);
    tap(0, 1, 20);
    chk("R3 partial", 32'(sw_rdata), 32'h011F);
    accept();
  endtask

  task automatic t_glitch;
    sw_write(16'h0A05);
    tap(1, 0, 2);
    chk("R1 glitch ignored", 32'(sw_rdata), 32'h0A05);
    chk("R1 glitch no req", 32'(cw_valid), 0);
  endtask

  task automatic t_repeat;
    int t;
    cw_ready = 1;
    sw_write(16'h1414);
    @(negedge clk); btn_up_n = 0;
    t = 0;
    while (sw_rdata == 16'h1414 && t < 40) begin @(negedge clk); t++; end
    cycles(90);
    btn_up_n = 1;
    cycles(30);
    chk("R4 repeat count", 32'(sw_rdata), 32'h0F0F);
    cw_ready = 0;
    cycles(2);
  endtask

  task automatic t_mute;
    sw_write(16'h0A05);
    tap(1, 1, 70);
    chk("R5 mute toggled", 32'(sw_rdata), 32'h8A05);
    chk("R5 request", 32'(cw_valid), 1);
    accept();
    tap(1, 1, 20);
    chk("R5 mute back", 32'(sw_rdata), 32'h0A05);
    accept();
  endtask

  task automatic t_supersede;
    sw_write(16'h0A05);
    tap(1, 0, 20);
    chk("R9 first pending", 32'(cw_data), 32'h0904);
    tap(1, 0, 20);
    chk("R9 newest data", 32'(cw_data), 32'h0803);
    accept();
    cycles(10);
    chk("R9 single request", 32'(cw_valid), 0);
  endtask

  task automatic t_sw_wins;
    @(negedge clk); btn_up_n = 0; sw_we = 1; sw_wdata = 16'h0C0C;
    cycles(20);
    btn_up_n = 1;
    cycles(10);
    sw_we = 0;
    cycles(10);
    chk("R7 sw wins", 32'(sw_rdata), 32'h0C0C);
    chk("R7 no request", 32'(cw_valid), 0);
  endtask

  task automatic t_mode_off;
    @(negedge clk); vol_mode = 0;
    tap(1, 0, 20);
    tap(1, 1, 20);
    chk("R10 mode off", 32'(sw_rdata), 32'h0C0C);
    chk("R10 no request", 32'(cw_valid), 0);
    vol_mode = 1;
    cycles(10);
  endtask

  initial begin
    cycles(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    cycles(2);
    t_sw_and_steps();
    t_saturate();
    t_glitch();
    t_repeat();
    t_mute();
    t_supersede();
    t_sw_wins();
    t_mode_off();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule